// File: doc/BRIEF.md
# Wiper Register File with Tap Decoder

This block holds the control state of one digitally set potentiometer. It keeps a live wiper code and four stored preset codes. It also drives a one-hot tap-select bus that closes exactly one switch on a chain of series resistor segments. For the default 6-bit code there are 64 taps on 63 segments. Tap 0 and the top tap are the two end terminals of the chain.

A serial front end issues commands over a valid/ready channel. Each command carries an opcode, a preset index and a data field, and can do one of four things:

- set the wiper code directly;
- store a preset;
- read a preset or the wiper;
- copy a preset into the wiper.

An active-low protect pin refuses preset stores. It does not touch wiper updates.

Read results leave on a second valid/ready channel. A result appears one cycle after its read is accepted, and it carries the value the register held when the read was accepted. While a result is waiting and `rsp_ready` is low, `cmd_ready` is low, so no command of any kind is taken. A result that is taken in the same cycle as a new command frees the slot for that command. The presets are plain flops and no analog behaviour is modelled.

Top module: `wiper_bank`

## Requirements
- R1: While reset is held and just after it, every preset holds RST_CODE (default 32), `wiper` equals preset 0, `tap` has only bit RST_CODE set, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: At all times after reset, exactly one bit of `tap` is high and its index equals `wiper`. Both change after the same clock edge. With the default parameters, code 0 selects `tap[0]` and code 63 selects `tap[63]`.
- R3: An accepted command with opcode 2'b00 loads `cmd_data` into `wiper` at that edge.
- R4: An accepted command with opcode 2'b01 while `wp_n` is 1 loads `cmd_data` into preset `cmd_idx`.
- R5: An accepted opcode 2'b01 command while `wp_n` is 0 is consumed but leaves every preset unchanged.
- R6: An accepted command with opcode 2'b11 copies preset `cmd_idx` into `wiper`. Neither this command nor opcode 2'b00 is affected by `wp_n`.
- R7: An accepted command with opcode 2'b10 returns preset `cmd_idx` when `cmd_data[0]` is 0, or `wiper` when `cmd_data[0]` is 1. The result appears on `rsp_data` with `rsp_valid` high in the cycle after acceptance, and it holds the value the register had at acceptance.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged and `cmd_ready` is 0. A command is accepted only when `cmd_valid` and `cmd_ready` are both high.
- R9: Opcodes 2'b00, 2'b01 and 2'b11 produce no result on the response channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Active-low protect; low refuses preset stores |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 00 set wiper, 01 store preset, 10 read, 11 copy preset to wiper |
| cmd_idx | input | IDX_W (2) | Preset index |
| cmd_data | input | W (6) | Code to write; bit 0 selects the wiper for reads |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | W (6) | Read result |
| wiper | output | W (6) | Live wiper code |
| tap | output | TAPS (64) | Registered one-hot tap select |

## Verification
Two events can share a cycle: a waiting result leaves while a new command, which may itself be a read, is accepted. The bench provokes this by running mixed command streams back to back while `rsp_ready` follows a pattern of two cycles high and one cycle low. The bench also inserts a long stall to hold a result. A scoreboard records each read's expected value at the moment the read is accepted. Every popped result is compared in order against that record, so a lost, duplicated or late-captured result shows up as a mismatch. Held results are also checked to stay stable from one cycle to the next.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [1:0] {
    OP_SET_WIPER = 2'b00,
    OP_STORE     = 2'b01,
    OP_READ      = 2'b10,
    OP_RECALL    = 2'b11
  } wiper_op_e;
endpackage

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int W        = 6,
  parameter int NUM_DR   = 4,
  parameter int RST_CODE = 32,
  localparam int IDX_W   = $clog2(NUM_DR)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wp_n,
  input  logic                       wr_req,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [W-1:0]               wr_data,
  output logic [NUM_DR-1:0][W-1:0]   dr_q
);
  logic wr_ok;
  assign wr_ok = wr_req && wp_n;

  for (genvar g = 0; g < NUM_DR; g++) begin : g_preset
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dr_q[g] <= W'(RST_CODE);
      else if (wr_ok && (wr_idx == IDX_W'(g)))
        dr_q[g] <= wr_data;
    end
  end

  // R5: protect low freezes every preset
  p_protect_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> $stable(dr_q));

  // R4: an allowed store lands in the addressed preset
  p_store_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wp_n) |=> dr_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int W        = 6,
  parameter int RST_CODE = 32,
  localparam int TAPS    = 1 << W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    code_d,
  output logic [TAPS-1:0] tap_q
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tap_q[i] <= (i == RST_CODE);
      else
        tap_q[i] <= (code_d == W'(i));
    end
  end

  // R2: a single closed switch at every cycle
  p_single_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_q) == 1);
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
  parameter int W        = 6,
  parameter int NUM_DR   = 4,
  parameter int RST_CODE = 32,
  localparam int IDX_W   = $clog2(NUM_DR),
  localparam int TAPS    = 1 << W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [W-1:0]     cmd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [W-1:0]     rsp_data,
  output logic [W-1:0]     wiper,
  output logic [TAPS-1:0]  tap
);
  import wiper_pkg::*;

  wiper_op_e                op;
  logic                     fire;
  logic [NUM_DR-1:0][W-1:0] dr_q;
  logic [W-1:0]             wiper_d, wiper_q;

  assign op        = wiper_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;

  wiper_store #(.W(W), .NUM_DR(NUM_DR), .RST_CODE(RST_CODE)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_n    (wp_n),
    .wr_req  (fire && (op == OP_STORE)),
    .wr_idx  (cmd_idx),
    .wr_data (cmd_data),
    .dr_q    (dr_q)
  );

  always_comb begin
    wiper_d = wiper_q;
    if (fire) begin
      case (op)
        OP_SET_WIPER: wiper_d = cmd_data;
        OP_RECALL:    wiper_d = dr_q[cmd_idx];
        default:      wiper_d = wiper_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper_q <= W'(RST_CODE);
    else        wiper_q <= wiper_d;
  end
  assign wiper = wiper_q;

  wiper_tap_decode #(.W(W), .RST_CODE(RST_CODE)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_d (wiper_d),
    .tap_q  (tap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire && (op == OP_READ)) begin
      rsp_valid <= 1'b1;
      rsp_data  <= cmd_data[0] ? wiper_q : dr_q[cmd_idx];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2: the closed tap follows the wiper code
  p_tap_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tap[wiper_q]);

  // R3: direct wiper load
  p_set_wiper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_SET_WIPER) |=> wiper_q == $past(cmd_data));

  // R6: preset copy reaches the wiper
  p_recall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_RECALL) |=> wiper_q == $past(dr_q[cmd_idx]));

  // R7: read result one cycle later
  p_read_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_READ) |=> rsp_valid);

  // R8: held result is stable
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9: non-read commands leave the response channel empty
  p_no_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op != OP_READ) |=> !rsp_valid);
endmodule

// File: tb/wiper_bank_test.sv
`timescale 1ns/1ps
module wiper_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wp_n = 1;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 0;
  logic [1:0]  cmd_idx = 0;
  logic [5:0]  cmd_data = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [5:0]  rsp_data;
  logic [5:0]  wiper;
  logic [63:0] tap;

  wiper_bank uut (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, ready_mode = 0;
  int m_dr[4];
  int m_w;
  logic [5:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // driver: model updated at acceptance, reads pushed to scoreboard
  task automatic send(input logic [1:0] op, input logic [1:0] idx, input logic [5:0] data, input string req);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_idx = idx; cmd_data = data;
    #1;
    while (!cmd_ready) begin
      @(negedge clk); #1;
    end
    case (op)
      2'b00: m_w = data;
      2'b01: if (wp_n) m_dr[idx] = data;
      2'b10: begin
        exp_q.push_back(data[0] ? 6'(m_w) : 6'(m_dr[idx]));
        tag_q.push_back(req);
      end
      default: m_w = m_dr[idx];
    endcase
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic check_wiper(input string req);
    check(wiper == 6'(m_w), {req, " wiper"}, 64'(wiper), 64'(m_w));
    check(tap == (64'd1 << m_w), {req, " tap"}, tap, 64'd1 << m_w);
  endtask

  // monitor: scoreboard pop and hold check
  logic [5:0] held;
  bit         was_held = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_ready = 1;
      was_held  = 0;
    end else begin
      cyc++;
      case (ready_mode)
        0: rsp_ready = 1;
        1: rsp_ready = (cyc % 3 != 0);
        default: rsp_ready = 0;
      endcase
      if (was_held)
        check(rsp_valid && rsp_data == held, "R8 held result stable", {57'd0, rsp_valid, rsp_data}, {57'd1, held});
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0)
          check(0, "R9 unexpected result", 64'(rsp_data), 64'd0);
        else begin
          string t;
          logic [5:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e, t, 64'(rsp_data), 64'(e));
        end
      end
      was_held = rsp_valid && !rsp_ready;
      held     = rsp_data;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_dr[i] = 32;
    m_w = 32;
    repeat (3) @(posedge clk);
    #1;
    check(wiper == 6'd32, "R1 reset wiper", 64'(wiper), 64'd32);
    check(tap == (64'd1 << 32), "R1 reset tap", tap, 64'd1 << 32);
    check(rsp_valid == 0, "R1 reset rsp_valid", 64'(rsp_valid), 0);
    check(cmd_ready == 1, "R1 reset cmd_ready", 64'(cmd_ready), 1);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 4; i++) send(2'b10, 2'(i), 6'd0, "R1 preset reset value");
    send(2'b10, 2'd0, 6'd1, "R7 read wiper");
    send(2'b00, 2'd0, 6'd5, "R3"); check_wiper("R3 set wiper 5");
    send(2'b00, 2'd0, 6'd0, "R2"); check_wiper("R2 bottom tap");
    send(2'b00, 2'd0, 6'd63, "R2"); check_wiper("R2 top tap");
    send(2'b01, 2'd1, 6'd17, "R4");
    send(2'b01, 2'd2, 6'd63, "R4");
    send(2'b01, 2'd3, 6'd0, "R4");
    for (int i = 0; i < 4; i++) send(2'b10, 2'(i), 6'd0, "R4 store readback");
    check_wiper("R9 stores leave wiper");
    wp_n = 0;
    send(2'b01, 2'd1, 6'd9, "R5");
    send(2'b10, 2'd1, 6'd0, "R5 protected store refused");
    send(2'b00, 2'd0, 6'd12, "R6"); check_wiper("R6 set under protect");
    send(2'b11, 2'd2, 6'd0, "R6"); check_wiper("R6 recall under protect");
    wp_n = 1;
    send(2'b11, 2'd3, 6'd0, "R6"); check_wiper("R6 recall preset 3");
    // mixed traffic under response back-pressure
    ready_mode = 1;
    for (int i = 0; i < 60; i++) begin
      wp_n = (i % 5 != 0);
      send(2'(i % 4), 2'((i * 3) % 4), 6'((i * 7 + 3) % 64), "R7 mixed stream read");
      check_wiper("R2 mixed stream");
    end
    wp_n = 1;
    ready_mode = 0;
    repeat (3) @(posedge clk);
    // long stall
    ready_mode = 2;
    send(2'b10, 2'd0, 6'd1, "R8 stalled read");
    repeat (3) @(posedge clk);
    #1;
    check(rsp_valid == 1, "R8 result held in stall", 64'(rsp_valid), 1);
    check(cmd_ready == 0, "R8 cmd blocked in stall", 64'(cmd_ready), 0);
    fork
      send(2'b00, 2'd0, 6'd40, "R8");
      begin repeat (4) @(posedge clk); ready_mode = 0; end
    join
    check_wiper("R8 command after stall");
    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R7 all results delivered", 64'(exp_q.size()), 0);
    check(rsp_valid == 0, "R9 channel idle", 64'(rsp_valid), 0);
    done = 1;
    summary();
  end
endmodule